// File: doc/BRIEF.md
# Link Packet Header Decoder

This block sits on the receive side of one serial link channel and watches the tokens the deserializer hands it. A token is either a data byte or a control code. Two of the control codes mark the end of a packet. After either of these markers, the decoder collects the next four data bytes as a packet header. It compares the header's destination byte with the channel's own address and sorts the command byte into one of three kinds: a data write, a plain control command or a safety-critical control command.

The outcome takes one of three forms. For an accepted write, the payload that follows is passed to the receive FIFO write port until the next marker. For an accepted control command, the decoder sends a one-cycle request to the command executor. Anything else produces a one-cycle error pulse. Every header byte is also presented to the acknowledge generator on an enable of its own. When the channel runs in transparent or wormhole-routing mode, the decoder steps aside and copies every token straight to the FIFO port.

All outputs are registered and change one clock after the token that causes them.

Top module: `link_hdr_decoder`

## Requirements
- R1: After reset, all output strobes are low and the decoder waits for an end-of-packet marker. Data bytes that arrive before the first marker are neither written nor acknowledged.
- R2: A token with tok_ctrl=1 and tok_data[1:0] equal to 2'b00 or 2'b01 is an end-of-packet marker. The next four data bytes form the header. Each header byte appears on ack_en/ack_data one cycle after it arrives, with ack_idx giving its position (0 to 3).
- R3: Header byte 0 is the destination address. If it differs from chan_addr, hdr_err pulses one cycle after header byte 3, no request is issued and no payload is written.
- R4: Header byte 1 selects the command. The value 0x01 with a matching address opens forwarding. Each later data byte then appears on fifo_wr_en/fifo_wr_data (fifo_wr_ctrl=0) one cycle after it arrives, until the next marker. The marker itself is not written.
- R5: A command byte in 0x14 to 0x17 with a matching address pulses cmd_req one cycle after header byte 3, with cmd_sel equal to the command minus 0x10. Data bytes that follow are not written.
- R6: Command bytes 0x10 to 0x13 are safety-critical. They are handled as in R5 only when safety_en is high in the cycle that header byte 3 arrives. Otherwise hdr_err pulses and no request is issued.
- R7: Any command byte other than 0x01 or 0x10 to 0x17 makes hdr_err pulse one cycle after header byte 3, with no request and no payload written.
- R8: A marker that arrives after one to three header bytes makes hdr_err pulse one cycle after the marker. The partial header is discarded and a new header starts.
- R9: In protocol mode, control tokens with tok_data[1:0] equal to 2'b10 or 2'b11 are ignored. The header position and the forwarding state are unchanged, and nothing is written.
- R10: When chan_mode is not 2'b00 (2'b01 transparent, 2'b10 wormhole), every valid token is copied to fifo_wr_en/fifo_wr_data/fifo_wr_ctrl one cycle later, and ack_en, cmd_req and hdr_err stay low. After a return to 2'b00, the decoder waits for a marker as in R1.
- R11: cmd_req and hdr_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_mode | input | 2 | 00 protocol, 01 transparent, 10 wormhole |
| chan_addr | input | 8 | Address of this channel |
| safety_en | input | 1 | Safety-critical commands currently allowed |
| tok_valid | input | 1 | Token strobe |
| tok_ctrl | input | 1 | Token is a control code (code in tok_data[1:0]) |
| tok_data | input | 8 | Data byte or control code |
| fifo_wr_en | output | 1 | Receive FIFO write strobe |
| fifo_wr_ctrl | output | 1 | Written token is a control code (bypass only) |
| fifo_wr_data | output | 8 | Receive FIFO write data |
| ack_en | output | 1 | Header byte strobe to the acknowledge generator |
| ack_idx | output | 2 | Header byte position |
| ack_data | output | 8 | Header byte |
| cmd_req | output | 1 | One-cycle request to the command executor |
| cmd_sel | output | 3 | Control command index, valid with cmd_req |
| hdr_err | output | 1 | One-cycle header error pulse |

## Verification
The bench uses the default parameters: a four-byte header with the address in byte 0 and the command in byte 1, write code 0x01, and eight control commands at 0x10 with the lower four safety-critical. With these values, every command class boundary can be reached with single header bytes: 0x0F, 0x10, 0x13, 0x14, 0x17 and 0x18. Cut headers of every length from one to three can also be reached. Both mode bypasses and the return to protocol mode are exercised, with idle gaps and ignored control codes mixed into headers and payloads.

// File: rtl/ldec_pkg.sv
package ldec_pkg;

  localparam int TOK_W = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PAYLOAD, ST_DRAIN} ldec_state_e;
  typedef enum logic [1:0] {CK_INVALID, CK_WRITE, CK_CTRL, CK_SAFE} cmd_kind_e;

  localparam logic [1:0] CC_EOP_A    = 2'b00;
  localparam logic [1:0] CC_EOP_B    = 2'b01;
  localparam logic [1:0] MODE_PROTO  = 2'b00;

  // True for either of the two end-of-packet control codes
  function automatic logic is_eop_code(input logic [1:0] code);
    return (code == CC_EOP_A) || (code == CC_EOP_B);
  endfunction

  // Sorts a command byte into its class
  function automatic cmd_kind_e classify_cmd(
    input logic [TOK_W-1:0] code,
    input logic [TOK_W-1:0] wr_code,
    input logic [TOK_W-1:0] ctl_base,
    input int               ctl_num,
    input int               safe_num
  );
    int off;
    off = int'(code) - int'(ctl_base);
    if (code == wr_code)              return CK_WRITE;
    if (off >= 0 && off < safe_num)   return CK_SAFE;
    if (off >= 0 && off < ctl_num)    return CK_CTRL;
    return CK_INVALID;
  endfunction

endpackage

// File: rtl/ldec_tok_decode.sv
module ldec_tok_decode
  import ldec_pkg::*;
(
  input  logic       proto,
  input  logic       tok_valid,
  input  logic       tok_ctrl,
  input  logic [1:0] tok_code,
  output logic       data_ev,
  output logic       eop_ev
);
  // Only protocol mode interprets tokens; other control codes produce no event
  always_comb begin
    data_ev = proto && tok_valid && !tok_ctrl;
    eop_ev  = proto && tok_valid && tok_ctrl && is_eop_code(tok_code);
  end
endmodule

// File: rtl/ldec_cmd_check.sv
module ldec_cmd_check
  import ldec_pkg::*;
#(
  parameter logic [TOK_W-1:0] CMD_WRITE = 8'h01,
  parameter logic [TOK_W-1:0] CTRL_BASE = 8'h10,
  parameter int               CTRL_NUM  = 8,
  parameter int               SAFE_NUM  = 4,
  localparam int              SEL_W     = $clog2(CTRL_NUM)
)(
  input  logic [TOK_W-1:0] hdr_addr,
  input  logic [TOK_W-1:0] hdr_cmd,
  input  logic [TOK_W-1:0] chan_addr,
  input  logic             safety_en,
  output cmd_kind_e        kind,
  output logic             ok_write,
  output logic             ok_ctrl,
  output logic             reject,
  output logic [SEL_W-1:0] ctrl_sel
);
  logic             addr_ok;
  logic [TOK_W-1:0] off;

  always_comb begin
    addr_ok  = (hdr_addr == chan_addr);
    kind     = classify_cmd(hdr_cmd, CMD_WRITE, CTRL_BASE, CTRL_NUM, SAFE_NUM);
    off      = hdr_cmd - CTRL_BASE;
    ctrl_sel = off[SEL_W-1:0];
    ok_write = addr_ok && (kind == CK_WRITE);
    ok_ctrl  = addr_ok && ((kind == CK_CTRL) || ((kind == CK_SAFE) && safety_en));
    reject   = !ok_write && !ok_ctrl;
  end
endmodule

// File: rtl/ldec_hdr_fsm.sv
module ldec_hdr_fsm
  import ldec_pkg::*;
#(
  parameter int  HDR_LEN  = 4,
  parameter int  ADDR_IDX = 0,
  parameter int  CMD_IDX  = 1,
  localparam int CNT_W    = $clog2(HDR_LEN)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proto,
  input  logic             data_ev,
  input  logic             eop_ev,
  input  logic [TOK_W-1:0] tok_data,
  input  logic             ok_write,
  output ldec_state_e      state_q,
  output logic [CNT_W-1:0] hdr_idx,
  output logic             hdr_char,
  output logic             hdr_last,
  output logic             hdr_cut,
  output logic             pay_char,
  output logic [TOK_W-1:0] eff_addr,
  output logic [TOK_W-1:0] eff_cmd
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0] A_IDX    = CNT_W'(ADDR_IDX);
  localparam logic [CNT_W-1:0] C_IDX    = CNT_W'(CMD_IDX);

  logic [CNT_W-1:0] cnt_q;
  logic [TOK_W-1:0] addr_q, cmd_q;
  ldec_state_e      state_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    hdr_idx  = cnt_q;
    hdr_char = data_ev && (state_q == ST_HDR);
    hdr_last = hdr_char && (cnt_q == LAST_IDX);
    hdr_cut  = eop_ev && (state_q == ST_HDR) && (cnt_q != '0);
    pay_char = data_ev && (state_q == ST_PAYLOAD);
    eff_addr = (hdr_char && cnt_q == A_IDX) ? tok_data : addr_q;
    eff_cmd  = (hdr_char && cnt_q == C_IDX) ? tok_data : cmd_q;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!proto) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (eop_ev) begin
      state_d = ST_HDR;
      cnt_d   = '0;
    end else if (hdr_char) begin
      if (hdr_last) begin
        state_d = ok_write ? ST_PAYLOAD : ST_DRAIN;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (hdr_char && cnt_q == A_IDX) addr_q <= tok_data;
      if (hdr_char && cnt_q == C_IDX) cmd_q  <= tok_data;
    end
  end
endmodule

// File: rtl/link_hdr_decoder.sv
module link_hdr_decoder
  import ldec_pkg::*;
#(
  parameter int          HDR_LEN   = 4,
  parameter int          ADDR_IDX  = 0,
  parameter int          CMD_IDX   = 1,
  parameter logic [7:0]  CMD_WRITE = 8'h01,
  parameter logic [7:0]  CTRL_BASE = 8'h10,
  parameter int          CTRL_NUM  = 8,
  parameter int          SAFE_NUM  = 4
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  chan_mode,
  input  logic [7:0]                  chan_addr,
  input  logic                        safety_en,
  input  logic                        tok_valid,
  input  logic                        tok_ctrl,
  input  logic [7:0]                  tok_data,
  output logic                        fifo_wr_en,
  output logic                        fifo_wr_ctrl,
  output logic [7:0]                  fifo_wr_data,
  output logic                        ack_en,
  output logic [$clog2(HDR_LEN)-1:0]  ack_idx,
  output logic [7:0]                  ack_data,
  output logic                        cmd_req,
  output logic [$clog2(CTRL_NUM)-1:0] cmd_sel,
  output logic                        hdr_err
);
  localparam int CNT_W = $clog2(HDR_LEN);
  localparam int SEL_W = $clog2(CTRL_NUM);

  // Named internal events, also observed by the bound checker
  logic             proto;
  logic             data_ev, eop_ev;
  ldec_state_e      state_q;
  logic [CNT_W-1:0] hdr_idx;
  logic             hdr_char, hdr_last, hdr_cut, pay_char;
  logic [7:0]       eff_addr, eff_cmd;
  cmd_kind_e        kind;
  logic             ok_write, ok_ctrl, reject;
  logic [SEL_W-1:0] ctrl_sel;
  logic             in_hdr, hdr_start, is_safe;

  assign proto     = (chan_mode == MODE_PROTO);
  assign in_hdr    = (state_q == ST_HDR);
  assign hdr_start = (hdr_idx == '0);
  assign is_safe   = (kind == CK_SAFE);

  ldec_tok_decode u_tok (
    .proto     (proto),
    .tok_valid (tok_valid),
    .tok_ctrl  (tok_ctrl),
    .tok_code  (tok_data[1:0]),
    .data_ev   (data_ev),
    .eop_ev    (eop_ev)
  );

  ldec_hdr_fsm #(
    .HDR_LEN  (HDR_LEN),
    .ADDR_IDX (ADDR_IDX),
    .CMD_IDX  (CMD_IDX)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .proto    (proto),
    .data_ev  (data_ev),
    .eop_ev   (eop_ev),
    .tok_data (tok_data),
    .ok_write (ok_write),
    .state_q  (state_q),
    .hdr_idx  (hdr_idx),
    .hdr_char (hdr_char),
    .hdr_last (hdr_last),
    .hdr_cut  (hdr_cut),
    .pay_char (pay_char),
    .eff_addr (eff_addr),
    .eff_cmd  (eff_cmd)
  );

  ldec_cmd_check #(
    .CMD_WRITE (CMD_WRITE),
    .CTRL_BASE (CTRL_BASE),
    .CTRL_NUM  (CTRL_NUM),
    .SAFE_NUM  (SAFE_NUM)
  ) u_chk_cmd (
    .hdr_addr  (eff_addr),
    .hdr_cmd   (eff_cmd),
    .chan_addr (chan_addr),
    .safety_en (safety_en),
    .kind      (kind),
    .ok_write  (ok_write),
    .ok_ctrl   (ok_ctrl),
    .reject    (reject),
    .ctrl_sel  (ctrl_sel)
  );

  // Output stage: every strobe is registered once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_wr_en   <= 1'b0;
      fifo_wr_ctrl <= 1'b0;
      fifo_wr_data <= '0;
      ack_en       <= 1'b0;
      ack_idx      <= '0;
      ack_data     <= '0;
      cmd_req      <= 1'b0;
      cmd_sel      <= '0;
      hdr_err      <= 1'b0;
    end else if (!proto) begin
      fifo_wr_en   <= tok_valid;
      fifo_wr_ctrl <= tok_ctrl;
      fifo_wr_data <= tok_data;
      ack_en       <= 1'b0;
      cmd_req      <= 1'b0;
      hdr_err      <= 1'b0;
    end else begin
      fifo_wr_en   <= pay_char;
      fifo_wr_ctrl <= 1'b0;
      fifo_wr_data <= tok_data;
      ack_en       <= hdr_char;
      ack_idx      <= hdr_idx;
      ack_data     <= tok_data;
      cmd_req      <= hdr_last && ok_ctrl;
      cmd_sel      <= (hdr_last && ok_ctrl) ? ctrl_sel : '0;
      hdr_err      <= (hdr_last && reject) || hdr_cut;
    end
  end
endmodule

// File: rtl/ldec_chk.sv
module ldec_chk (
  input logic clk,
  input logic rst_n,
  input logic proto,
  input logic eop_ev,
  input logic pay_char,
  input logic hdr_last,
  input logic hdr_cut,
  input logic in_hdr,
  input logic hdr_start,
  input logic is_safe,
  input logic safety_en,
  input logic fifo_wr_en,
  input logic fifo_wr_ctrl,
  input logic ack_en,
  input logic cmd_req,
  input logic hdr_err
);
  // R10
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proto |=> (!ack_en && !cmd_req && !hdr_err));

  // R2
  eop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_ev |=> (in_hdr && hdr_start));

  // R4
  payload_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_char |=> (fifo_wr_en && !fifo_wr_ctrl));

  // R8
  cut_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_cut |=> (hdr_err && !cmd_req));

  // R6
  safety_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_last && is_safe && !safety_en) |=> (hdr_err && !cmd_req));

  // R11
  req_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_req && hdr_err));

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);
endmodule

bind link_hdr_decoder ldec_chk u_ldec_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .proto        (proto),
  .eop_ev       (eop_ev),
  .pay_char     (pay_char),
  .hdr_last     (hdr_last),
  .hdr_cut      (hdr_cut),
  .in_hdr       (in_hdr),
  .hdr_start    (hdr_start),
  .is_safe      (is_safe),
  .safety_en    (safety_en),
  .fifo_wr_en   (fifo_wr_en),
  .fifo_wr_ctrl (fifo_wr_ctrl),
  .ack_en       (ack_en),
  .cmd_req      (cmd_req),
  .hdr_err      (hdr_err)
);

// File: tb/link_hdr_decoder_tb.sv
`timescale 1ns/1ps
module link_hdr_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_mode = 2'b00;
  logic [7:0] chan_addr = 8'h5A;
  logic       safety_en = 1'b0;
  logic       tok_valid = 1'b0;
  logic       tok_ctrl = 1'b0;
  logic [7:0] tok_data = 8'h00;
  logic       fifo_wr_en, fifo_wr_ctrl, ack_en, cmd_req, hdr_err;
  logic [7:0] fifo_wr_data, ack_data;
  logic [1:0] ack_idx;
  logic [2:0] cmd_sel;

  always #4 clk = ~clk; // 125 MHz

  link_hdr_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode), .chan_addr(chan_addr),
    .safety_en(safety_en), .tok_valid(tok_valid), .tok_ctrl(tok_ctrl),
    .tok_data(tok_data), .fifo_wr_en(fifo_wr_en), .fifo_wr_ctrl(fifo_wr_ctrl),
    .fifo_wr_data(fifo_wr_data), .ack_en(ack_en), .ack_idx(ack_idx),
    .ack_data(ack_data), .cmd_req(cmd_req), .cmd_sel(cmd_sel), .hdr_err(hdr_err)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // Reference model state: 0 waiting, 1 header, 2 payload, 3 discard
  int       m_phase = 0;
  byte      m_hdr[$];
  int       e_fwr, e_fctl, e_fdat, e_ack, e_aidx, e_adat, e_req, e_sel, e_err;

  always @(posedge clk) begin
    e_fwr = 0; e_ack = 0; e_req = 0; e_err = 0;
    if (!rst_n) begin
      m_phase = 0; m_hdr.delete();
    end else if (chan_mode != 2'b00) begin
      e_fwr = tok_valid; e_fctl = tok_ctrl; e_fdat = tok_data;
      m_phase = 0; m_hdr.delete();
    end else if (tok_valid && tok_ctrl) begin
      if (tok_data[1:0] == 2'b00 || tok_data[1:0] == 2'b01) begin
        if (m_phase == 1 && m_hdr.size() > 0) e_err = 1;
        m_phase = 1; m_hdr.delete();
      end
    end else if (tok_valid) begin
      if (m_phase == 2) begin
        e_fwr = 1; e_fctl = 0; e_fdat = tok_data;
      end else if (m_phase == 1) begin
        e_ack = 1; e_aidx = m_hdr.size(); e_adat = tok_data;
        m_hdr.push_back(tok_data);
        if (m_hdr.size() == 4) begin
          int a, c;
          a = m_hdr[0]; c = m_hdr[1];
          a = a & 255; c = c & 255;
          m_phase = 3;
          if (a != chan_addr) e_err = 1;
          else if (c == 1) m_phase = 2;
          else if (c >= 16 && c <= 23) begin
            if (c <= 19 && !safety_en) e_err = 1;
            else begin e_req = 1; e_sel = c - 16; end
          end else e_err = 1;
          m_hdr.delete();
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  // One token per call; compare all outputs two ns after the edge
  task automatic tok(bit v, bit c, logic [7:0] d);
    tok_valid = v; tok_ctrl = c; tok_data = d;
    @(posedge clk); #2;
    chk("fifo_wr_en", fifo_wr_en, e_fwr);
    if (e_fwr) begin
      chk("fifo_wr_data", fifo_wr_data, e_fdat);
      chk("fifo_wr_ctrl", fifo_wr_ctrl, e_fctl);
    end
    chk("ack_en", ack_en, e_ack);
    if (e_ack) begin
      chk("ack_idx", ack_idx, e_aidx);
      chk("ack_data", ack_data, e_adat);
    end
    chk("cmd_req", cmd_req, e_req);
    if (e_req) chk("cmd_sel", cmd_sel, e_sel);
    chk("hdr_err", hdr_err, e_err);
    chk("req_err_excl", int'(cmd_req && hdr_err), 0); // R11
  endtask

  task automatic dat(logic [7:0] d); tok(1, 0, d); endtask
  task automatic ctl(logic [1:0] code); tok(1, 1, {6'd0, code}); endtask
  task automatic gap(); tok(0, 0, 8'hEE); endtask
  task automatic hdr(logic [7:0] a, logic [7:0] c);
    dat(a); dat(c); dat(8'h33); dat(8'h44);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("reset fifo_wr_en", fifo_wr_en, 0);
    chk("reset ack_en", ack_en, 0);
    chk("reset cmd_req", cmd_req, 0);
    chk("reset hdr_err", hdr_err, 0);
    rst_n = 1;
    // R1: data before first marker is dropped
    cur_req = "R1"; dat(8'h5A); dat(8'h01); dat(8'h11); gap();
    // R2 R4: EOP1 then write header, payload, closed by EOP2
    cur_req = "R4"; ctl(2'b00); hdr(8'h5A, 8'h01); dat(8'hA1); gap(); dat(8'hA2); dat(8'hA3); ctl(2'b01);
    // R3: address mismatch
    cur_req = "R3"; hdr(8'h5B, 8'h01); dat(8'hB1); ctl(2'b01);
    // R5: plain control commands at both ends
    cur_req = "R5"; hdr(8'h5A, 8'h14); dat(8'hC1); ctl(2'b00);
    hdr(8'h5A, 8'h17); dat(8'hC2); ctl(2'b01);
    // R6: safety-critical blocked then allowed
    cur_req = "R6"; safety_en = 0; hdr(8'h5A, 8'h10); ctl(2'b00);
    hdr(8'h5A, 8'h13); ctl(2'b00);
    safety_en = 1; hdr(8'h5A, 8'h10); ctl(2'b00);
    hdr(8'h5A, 8'h13); ctl(2'b01); safety_en = 0;
    // R7: invalid command bytes
    cur_req = "R7"; hdr(8'h5A, 8'h0F); dat(8'hD1); ctl(2'b00);
    hdr(8'h5A, 8'h18); ctl(2'b00); hdr(8'h5A, 8'h00); ctl(2'b00);
    hdr(8'h5A, 8'hFF); ctl(2'b00);
    // R8: cut headers of length 1, 2, 3 and back-to-back markers
    cur_req = "R8"; dat(8'h5A); ctl(2'b00);
    dat(8'h5A); dat(8'h01); ctl(2'b01);
    dat(8'h5A); dat(8'h01); dat(8'h33); ctl(2'b00);
    ctl(2'b01); hdr(8'h5A, 8'h01); dat(8'hE1); ctl(2'b00);
    // R9: other control codes ignored inside header and payload
    cur_req = "R9"; dat(8'h5A); ctl(2'b10); dat(8'h01); ctl(2'b11); dat(8'h33); dat(8'h44);
    dat(8'hF1); ctl(2'b10); dat(8'hF2); ctl(2'b00);
    // R10: bypass modes then return
    cur_req = "R10"; chan_mode = 2'b01; dat(8'h5A); ctl(2'b00); dat(8'h01); ctl(2'b11); gap();
    chan_mode = 2'b10; dat(8'h77); ctl(2'b01); hdr(8'h5A, 8'h15);
    chan_mode = 2'b00; dat(8'h5A); dat(8'h01); dat(8'h00); dat(8'h00); dat(8'h99);
    ctl(2'b00); hdr(8'h5A, 8'h01); dat(8'h12);
    chan_mode = 2'b01; dat(8'h13); chan_mode = 2'b00; dat(8'h14); ctl(2'b00);
    // R3 with a different channel address
    cur_req = "R3"; chan_addr = 8'hC3; hdr(8'h5A, 8'h01); dat(8'h21); ctl(2'b00);
    cur_req = "R4"; hdr(8'hC3, 8'h01); dat(8'h22); ctl(2'b01);
    gap(); gap();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule